// File: doc/BRIEF.md
# Ping-Pong Bulk OUT Receive Buffer

This block stores packets arriving on a bulk OUT endpoint in two 64-byte halves that swap owners. The link layer writes one packet into whichever half it currently owns. When the packet ends, the block records how many bytes it held and hands that half to the processor. The processor pulls bytes from the half it currently owns, watches a size output that reports how many bytes are valid there, and then pulses a read-done strobe. The strobe hands the half back to the link side and moves the processor's view to the other half.

While the processor drains one half, the link layer can fill the other. When both halves are waiting for the processor, a buffer-available output goes low so that the link layer answers the host with NAK. A clear command empties both halves. An over-read flag catches a processor that reads more bytes than a half holds.

Top module: `pp_rx_fifo`

## Requirements
- R1: After reset, cpu_data_ready and cpu_overread are 0, cpu_rx_size is 0, usb_buf_avail is 1 and usb_rx_active is 0.
- R2: Bytes accepted through usb_wr_en are returned on cpu_rd_data in arrival order. Each byte appears one cycle after the cpu_rd_en cycle that requests it. A usb_pkt_end pulse on its own cycle closes the packet and records its byte count.
- R3: Halves are filled alternately, beginning with half 0 after reset or clear. usb_buf_avail is 0 while the half being filled is still owned by the processor. In that state, usb_wr_en and usb_pkt_end are ignored.
- R4: Bytes beyond the 64th of one packet are dropped, and the recorded count stops at 64.
- R5: cpu_rx_size equals the recorded count of the processor's current half while that half is full, and 0 otherwise. cpu_data_ready is 1 exactly when that half is full.
- R6: A cpu_rd_en while cpu_data_ready is 0, or after cpu_rx_size bytes of the half have been read, sets cpu_overread. The flag stays set until an accepted read-done or clear, and the data returned by such a read is undefined.
- R7: cpu_rd_done while the current half is full empties that half, switches the processor to the other half, restarts its read position and clears cpu_overread.
- R8: cpu_rd_done while the current half is empty changes nothing: the processor keeps its half and its read position.
- R9: cpu_fifo_clr while usb_rx_active is 0 empties both halves, returns both selections to half 0 and clears cpu_overread.
- R10: cpu_fifo_clr is ignored while usb_rx_active is 1, that is, after the first byte of a packet has been accepted and before its usb_pkt_end.
- R11: A usb_pkt_end with no preceding bytes marks the half full with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_wr_en | input | 1 | Received byte strobe |
| usb_wr_data | input | DW | Received byte |
| usb_pkt_end | input | 1 | End of packet, on a cycle of its own |
| usb_buf_avail | output | 1 | The half being filled can take data; low means answer NAK |
| usb_rx_active | output | 1 | A packet is partly received |
| cpu_rd_en | input | 1 | Read one byte from the current half |
| cpu_rd_data | output | DW | Read byte, valid the cycle after cpu_rd_en |
| cpu_rd_done | input | 1 | Read-done strobe: release the current half |
| cpu_fifo_clr | input | 1 | Empty both halves |
| cpu_rx_size | output | CW | Valid bytes in the current half |
| cpu_data_ready | output | 1 | Current half is full |
| cpu_overread | output | 1 | Sticky over-read flag |

## Verification
The bench uses the defaults DW=8 and DEPTH=64. With these values the 64-byte limit of a half is reached by a single full packet, and a 70-byte packet pushes past it into the drop path. At this depth, two packets fill both halves within a few hundred cycles, so the NAK condition and the ignored third packet are exercised. The clear-while-receiving case, the zero-length packet and reads past the end of a half all occur inside one short sequence.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_t;

  // The half that follows s in the ping-pong order.
  function automatic side_t other_side(input side_t s);
    return (s == SIDE_A) ? SIDE_B : SIDE_A;
  endfunction

  // A byte can be read only from a full half, below its recorded count.
  function automatic logic byte_readable(input int unsigned ptr,
                                         input int unsigned cnt,
                                         input logic        full);
    return full && (ptr < cnt);
  endfunction

  // A byte can be stored only while the packet is below the half's capacity.
  function automatic logic room_left(input int unsigned ptr,
                                     input int unsigned depth);
    return ptr < depth;
  endfunction

endpackage

// File: rtl/pp_side_buf.sv
module pp_side_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_cnt,
  input  logic          release_i,
  input  logic          clear_i,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic [CW-1:0] cnt
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      cnt  <= '0;
    end else if (clear_i) begin
      full <= 1'b0;
      cnt  <= '0;
    end else if (commit) begin
      full <= 1'b1;
      cnt  <= commit_cnt;
    end else if (release_i) begin
      full <= 1'b0;
      cnt  <= '0;
    end
  end

endmodule

// File: rtl/pp_usb_fill.sv
module pp_usb_fill
  import pp_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          pkt_end,
  input  logic          clear_ok,
  input  logic [1:0]    side_full,
  output side_t         fill_side,
  output logic          buf_avail,
  output logic          rx_active,
  output logic [CW-1:0] wr_ptr,
  output logic          byte_we,
  output logic          commit,
  output logic [CW-1:0] commit_cnt
);

  assign buf_avail  = !side_full[fill_side];
  assign byte_we    = wr_en && buf_avail && !clear_ok &&
                      room_left(32'(wr_ptr), DEPTH);
  assign commit     = pkt_end && buf_avail && !clear_ok;
  assign commit_cnt = wr_ptr + CW'(byte_we);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_side <= SIDE_A;
      wr_ptr    <= '0;
      rx_active <= 1'b0;
    end else if (clear_ok) begin
      fill_side <= SIDE_A;
      wr_ptr    <= '0;
      rx_active <= 1'b0;
    end else if (commit) begin
      fill_side <= other_side(fill_side);
      wr_ptr    <= '0;
      rx_active <= 1'b0;
    end else if (wr_en && buf_avail) begin
      rx_active <= 1'b1;
      if (byte_we) wr_ptr <= wr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/pp_cpu_read.sv
module pp_cpu_read
  import pp_rx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_done,
  input  logic          clear_ok,
  input  logic          cur_full,
  input  logic [CW-1:0] cur_cnt,
  input  logic [DW-1:0] cur_data,
  output side_t         cpu_side,
  output logic [CW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data,
  output logic          overread,
  output logic          done_accept,
  output logic          overread_evt
);

  logic rd_hit;

  assign rd_hit       = rd_en && !clear_ok &&
                        byte_readable(32'(rd_ptr), 32'(cur_cnt), cur_full);
  assign overread_evt = rd_en && !clear_ok && !rd_hit;
  assign done_accept  = rd_done && cur_full && !clear_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_side <= SIDE_A;
      rd_ptr   <= '0;
    end else if (clear_ok) begin
      cpu_side <= SIDE_A;
      rd_ptr   <= '0;
    end else if (done_accept) begin
      cpu_side <= other_side(cpu_side);
      rd_ptr   <= '0;
    end else if (rd_hit) begin
      rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overread <= 1'b0;
    end else if (clear_ok) begin
      overread <= 1'b0;
    end else if (overread_evt) begin
      overread <= 1'b1;
    end else if (done_accept) begin
      overread <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_hit) rd_data <= cur_data;
    else if (rd_en)  rd_data <= '0;
  end

endmodule

// File: rtl/pp_rx_fifo.sv
module pp_rx_fifo
  import pp_rx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usb_wr_en,
  input  logic [DW-1:0] usb_wr_data,
  input  logic          usb_pkt_end,
  output logic          usb_buf_avail,
  output logic          usb_rx_active,
  input  logic          cpu_rd_en,
  output logic [DW-1:0] cpu_rd_data,
  input  logic          cpu_rd_done,
  input  logic          cpu_fifo_clr,
  output logic [CW-1:0] cpu_rx_size,
  output logic          cpu_data_ready,
  output logic          cpu_overread
);

  // Named internal events
  logic          clr_accept;
  logic          byte_we;
  logic          pkt_commit;
  logic          done_accept;
  logic          overread_evt;
  side_t         fill_side;
  side_t         cpu_side;
  logic [CW-1:0] wr_ptr;
  logic [CW-1:0] rd_ptr;
  logic [CW-1:0] commit_cnt;
  logic [1:0]    side_full;
  logic [CW-1:0] side_cnt   [2];
  logic [DW-1:0] side_rdata [2];
  logic          cur_full;
  logic [CW-1:0] cur_cnt;

  assign clr_accept = cpu_fifo_clr && !usb_rx_active;

  pp_usb_fill #(.DEPTH(DEPTH)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (usb_wr_en),
    .pkt_end    (usb_pkt_end),
    .clear_ok   (clr_accept),
    .side_full  (side_full),
    .fill_side  (fill_side),
    .buf_avail  (usb_buf_avail),
    .rx_active  (usb_rx_active),
    .wr_ptr     (wr_ptr),
    .byte_we    (byte_we),
    .commit     (pkt_commit),
    .commit_cnt (commit_cnt)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    pp_side_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (byte_we && (fill_side == side_t'(s))),
      .wr_addr    (wr_ptr[AW-1:0]),
      .wr_data    (usb_wr_data),
      .commit     (pkt_commit && (fill_side == side_t'(s))),
      .commit_cnt (commit_cnt),
      .release_i  (done_accept && (cpu_side == side_t'(s))),
      .clear_i    (clr_accept),
      .rd_addr    (rd_ptr[AW-1:0]),
      .rd_data    (side_rdata[s]),
      .full       (side_full[s]),
      .cnt        (side_cnt[s])
    );
  end

  assign cur_full = side_full[cpu_side];
  assign cur_cnt  = side_cnt[cpu_side];

  pp_cpu_read #(.DW(DW), .DEPTH(DEPTH)) u_read (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (cpu_rd_en),
    .rd_done      (cpu_rd_done),
    .clear_ok     (clr_accept),
    .cur_full     (cur_full),
    .cur_cnt      (cur_cnt),
    .cur_data     (side_rdata[cpu_side]),
    .cpu_side     (cpu_side),
    .rd_ptr       (rd_ptr),
    .rd_data      (cpu_rd_data),
    .overread     (cpu_overread),
    .done_accept  (done_accept),
    .overread_evt (overread_evt)
  );

  assign cpu_data_ready = cur_full;
  assign cpu_rx_size    = cur_full ? cur_cnt : '0;

endmodule

// File: rtl/pp_rx_fifo_chk.sv
module pp_rx_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          usb_pkt_end,
  input logic          usb_rx_active,
  input logic          usb_buf_avail,
  input logic          cpu_rd_en,
  input logic          cpu_rd_done,
  input logic          cpu_fifo_clr,
  input logic [CW-1:0] cpu_rx_size,
  input logic          cpu_data_ready,
  input logic          cpu_overread,
  input logic [1:0]    side_full,
  input logic          cpu_side,
  input logic [CW-1:0] rd_ptr,
  input logic [CW-1:0] wr_ptr,
  input logic          clr_accept
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_ptr) <= DEPTH); // R4

  AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cpu_rx_size) <= DEPTH); // R5

  AST_EMPTY_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_data_ready |-> cpu_rx_size == '0); // R5

  AST_BOTH_FULL_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (side_full == 2'b11) |-> !usb_buf_avail); // R3

  AST_OVERREAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && !clr_accept && int'(rd_ptr) >= int'(cpu_rx_size))
      |=> cpu_overread); // R6

  AST_DONE_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_done && cpu_data_ready && !clr_accept)
      |=> (cpu_side != $past(cpu_side)) && !cpu_overread); // R7

  AST_DONE_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_done && !cpu_data_ready && !cpu_fifo_clr)
      |=> $stable(cpu_side) && $stable(rd_ptr)); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fifo_clr && !usb_rx_active)
      |=> (side_full == 2'b00) && !cpu_overread && (cpu_side == 1'b0)); // R9

  AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fifo_clr && usb_rx_active && !usb_pkt_end) |=> usb_rx_active); // R10

endmodule

bind pp_rx_fifo pp_rx_fifo_chk #(.DEPTH(DEPTH)) u_pp_rx_fifo_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .usb_pkt_end    (usb_pkt_end),
  .usb_rx_active  (usb_rx_active),
  .usb_buf_avail  (usb_buf_avail),
  .cpu_rd_en      (cpu_rd_en),
  .cpu_rd_done    (cpu_rd_done),
  .cpu_fifo_clr   (cpu_fifo_clr),
  .cpu_rx_size    (cpu_rx_size),
  .cpu_data_ready (cpu_data_ready),
  .cpu_overread   (cpu_overread),
  .side_full      (side_full),
  .cpu_side       (cpu_side),
  .rd_ptr         (rd_ptr),
  .wr_ptr         (wr_ptr),
  .clr_accept     (clr_accept)
);

// File: tb/test_pp_rx_fifo.sv
`timescale 1ns/1ps
module test_pp_rx_fifo;

  localparam int DW    = 8;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          usb_wr_en = 1'b0;
  logic [DW-1:0] usb_wr_data = '0;
  logic          usb_pkt_end = 1'b0;
  logic          usb_buf_avail;
  logic          usb_rx_active;
  logic          cpu_rd_en = 1'b0;
  logic [DW-1:0] cpu_rd_data;
  logic          cpu_rd_done = 1'b0;
  logic          cpu_fifo_clr = 1'b0;
  logic [CW-1:0] cpu_rx_size;
  logic          cpu_data_ready;
  logic          cpu_overread;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  logic          expect_data = 1'b0;
  logic          rd_q = 1'b0;

  always #2.5 clk = ~clk;

  pp_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_pp_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .usb_wr_en(usb_wr_en), .usb_wr_data(usb_wr_data), .usb_pkt_end(usb_pkt_end),
    .usb_buf_avail(usb_buf_avail), .usb_rx_active(usb_rx_active),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_rd_done(cpu_rd_done),
    .cpu_fifo_clr(cpu_fifo_clr), .cpu_rx_size(cpu_rx_size),
    .cpu_data_ready(cpu_data_ready), .cpu_overread(cpu_overread)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: a requested byte appears one cycle after cpu_rd_en (R2)
  always @(posedge clk) rd_q <= cpu_rd_en && expect_data;

  always @(negedge clk) begin
    if (rd_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 actual=%0d expected=none (queue empty)", cpu_rd_data);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (cpu_rd_data !== e) begin
          errors++;
          $display("FAIL R2 actual=%0d expected=%0d", cpu_rd_data, e);
        end
      end
    end
  end

  // Driver: push stored bytes into the scoreboard when the packet is accepted
  task automatic send_pkt(input int n, input int base, input bit push, input bit close);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      usb_wr_en   = 1'b1;
      usb_wr_data = DW'(base + i);
      if (push && i < DEPTH) exp_q.push_back(DW'(base + i));
    end
    @(negedge clk);
    usb_wr_en = 1'b0;
    if (close) begin
      usb_pkt_end = 1'b1;
      @(negedge clk);
      usb_pkt_end = 1'b0;
    end
  endtask

  task automatic read_bytes(input int n, input bit valid);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_rd_en   = 1'b1;
      expect_data = valid;
    end
    @(negedge clk);
    cpu_rd_en   = 1'b0;
    expect_data = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    cpu_rd_done = 1'b1;
    @(negedge clk);
    cpu_rd_done = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    cpu_fifo_clr = 1'b1;
    @(negedge clk);
    cpu_fifo_clr = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data_ready", cpu_data_ready, 0);
    chk("R1 rx_size", cpu_rx_size, 0);
    chk("R1 buf_avail", usb_buf_avail, 1);
    chk("R1 overread", cpu_overread, 0);
    chk("R1 rx_active", usb_rx_active, 0);

    // R2/R5: 10-byte packet into half 0
    send_pkt(10, 8'h10, 1, 1);
    chk("R5 data_ready", cpu_data_ready, 1);
    chk("R5 rx_size", cpu_rx_size, 10);
    chk("R3 other half free", usb_buf_avail, 1);

    // R3: 64-byte packet into half 1, then both full
    send_pkt(64, 8'h40, 1, 1);
    chk("R3 both full nak", usb_buf_avail, 0);
    chk("R5 size unchanged", cpu_rx_size, 10);

    // R3: packet offered while no half is free is dropped
    send_pkt(5, 8'hE0, 0, 1);
    chk("R3 ignored size", cpu_rx_size, 10);
    chk("R3 ignored nak", usb_buf_avail, 0);
    chk("R3 ignored inactive", usb_rx_active, 0);

    // R2 read half 0, R6 over-read by one
    read_bytes(10, 1);
    chk("R6 no flag at limit", cpu_overread, 0);
    read_bytes(1, 0);
    chk("R6 overread set", cpu_overread, 1);
    read_bytes(0, 0);
    chk("R6 overread sticky", cpu_overread, 1);

    // R7 switch to half 1
    pulse_done();
    chk("R7 new size", cpu_rx_size, 64);
    chk("R7 overread cleared", cpu_overread, 0);
    chk("R7 half released", usb_buf_avail, 1);
    read_bytes(64, 1);
    pulse_done();
    chk("R7 now empty ready", cpu_data_ready, 0);
    chk("R7 now empty size", cpu_rx_size, 0);

    // R8 read-done on an empty half, then a packet lands in half 0
    pulse_done();
    chk("R8 still empty", cpu_data_ready, 0);
    send_pkt(3, 8'h90, 0, 1);
    chk("R8 view kept on half 0", cpu_rx_size, 3);

    // R9 clear while idle
    pulse_clr();
    chk("R9 ready", cpu_data_ready, 0);
    chk("R9 size", cpu_rx_size, 0);
    chk("R9 avail", usb_buf_avail, 1);

    // R10 clear while a packet is partly received
    send_pkt(2, 8'hA0, 1, 0);
    chk("R10 active", usb_rx_active, 1);
    pulse_clr();
    chk("R10 still active", usb_rx_active, 1);
    send_pkt(2, 8'hA2, 1, 1);
    chk("R10 size kept", cpu_rx_size, 4);
    read_bytes(4, 1);
    pulse_done();

    // R4 oversize packet into half 1
    send_pkt(70, 8'h00, 1, 1);
    chk("R4 count capped", cpu_rx_size, 64);
    read_bytes(64, 1);
    read_bytes(1, 0);
    chk("R4 no extra byte", cpu_overread, 1);
    pulse_done();

    // R11 zero-length packet into half 0
    send_pkt(0, 0, 0, 1);
    chk("R11 ready", cpu_data_ready, 1);
    chk("R11 size", cpu_rx_size, 0);
    read_bytes(1, 0);
    chk("R11 overread", cpu_overread, 1);
    pulse_done();
    chk("R11 released", cpu_data_ready, 0);

    // R6 read with nothing ready
    read_bytes(1, 0);
    chk("R6 empty read", cpu_overread, 1);

    repeat (2) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    summary();
  end

endmodule